// File: doc/BRIEF.md
# Three-Channel Chainable Timer/Counter

This block holds three identical 16-bit counting channels behind one small register bus. Each channel picks one of eight count sources and advances on every rising edge of that source. The count sources are five divided-clock taps made outside the block and three routed lines. A channel runs in one of two modes. In capture mode an edge on its input pin copies the live count into a capture register, which is used for interval, frequency and event measurement. In waveform mode the count restarts on a period match and drives a pulse or PWM output.

Two controls act on the whole block. A sync command clears and starts all three channels on the same clock edge. A routing setting chooses, for each of the three routed lines, either an external clock pin or the waveform output of the previous channel. This lets channels be chained into a longer counter. Each channel raises its own maskable interrupt from three sticky status flags, and reading the status clears them.

Top module: `tmr_block`

## Requirements
- R1: After reset every counter, capture register, status flag, waveform output and interrupt is zero, and every channel is stopped.
- R2: Channel i has registers at byte address 8*i + offset. A control write (offset 0) sets the source in bits [2:0]: values 0..4 select internal tap 0..4, and values 5..7 select routed line 0..2. An enabled channel adds one to its count (offset 2, read) on each rising edge of that source.
- R3: A command write (offset 1) enables with bit 0, disables with bit 1 (disable wins), and triggers with bit 2. A trigger clears the count and enables the channel. Reading offset 1 returns the enable state in bit 0, and a disabled channel ignores source edges.
- R4: Writing bit 0 of address 0x20 triggers all three channels on the same edge.
- R5: The routing register at 0x21 holds two bits per routed line k at [2k+1:2k]. Value 0 routes external clock pin k, value 1 routes the waveform output of channel (k+2) mod 3, and values 2 and 3 route a constant low.
- R6: With control bit 3 set (waveform mode), a count edge that finds the count equal to the period register (offset 4) returns the count to zero and sets status bit 1.
- R7: In waveform mode the output goes high on a trigger or a period restart and goes low on the count edge that makes the count equal the duty register (offset 3). In capture mode the output is low.
- R8: In capture mode an edge on the channel's capture pin copies the count into the capture register (offset 5) and sets status bit 2. Control bits [5:4] pick the edge: bit 4 for rising, bit 5 for falling. Edges that are not selected are ignored.
- R9: A count edge that finds the count at 0xFFFF, and is not a period restart, wraps the count to 0 and sets status bit 0.
- R10: Reading status (offset 6) returns bits [2:0] and clears them. A new event in the same cycle wins over the clear. The channel interrupt is high while any status bit that is enabled in the mask (offset 7) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered one cycle after bus_rd |
| int_clk | input | 5 | Internal divided-clock taps |
| ext_clk | input | 3 | External clock pins |
| cap_in | input | 3 | Capture input pin per channel |
| wave_out | output | 3 | Waveform output per channel |
| irq | output | 3 | Interrupt per channel |

## Verification
Register writes, triggers, count edges, captures and status changes all take effect on the clock edge that samples the stimulus. A chained channel sees the output of the previous channel one edge later, because that output is registered. Read data appears one edge after the read strobe. The bench drives all inputs at the falling edge, so every counter, flag, output and interrupt result is checked at the next falling edge. The scoreboard monitor pops an expected read value only at the falling edge that follows the edge on which it saw the read strobe.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int ADDR_W = 6;
   localparam logic [2:0] OFS_CTRL = 3'd0;
   localparam logic [2:0] OFS_CMD  = 3'd1;
   localparam logic [2:0] OFS_CNT  = 3'd2;
   localparam logic [2:0] OFS_DUTY = 3'd3;
   localparam logic [2:0] OFS_PER  = 3'd4;
   localparam logic [2:0] OFS_CAP  = 3'd5;
   localparam logic [2:0] OFS_STAT = 3'd6;
   localparam logic [2:0] OFS_IE   = 3'd7;

   typedef struct packed {
      logic [1:0] cap_edge;
      logic       wave;
      logic [2:0] clk_sel;
   } ch_cfg_t;
endpackage

// File: rtl/tmr_clksel.sv
module tmr_clksel #(
   parameter int NINT = 5,
   parameter int NXC  = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NINT-1:0] int_tick,
   input  logic [NXC-1:0]  xc,
   input  logic [2:0]      sel,
   output logic            tick
);
   localparam int NSRC = NINT + NXC;
   logic [NSRC-1:0] srcs;
   logic            src, src_q;

   assign srcs = {xc, int_tick};
   assign src  = srcs[sel];

   always_ff @(posedge clk) begin
      if (!rst_n) src_q <= 1'b0;
      else        src_q <= src;
   end

   assign tick = src & ~src_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          cap_pin,
   input  logic          sync,
   input  logic          wr,
   input  logic          stat_rd,
   input  logic [2:0]    ofs,
   input  logic [CW-1:0] wdata,
   output logic [2:0]    clk_sel,
   output logic          out_a,
   output logic          irq,
   output logic [CW-1:0] cnt,
   output logic [CW-1:0] cap,
   output logic [2:0]    status,
   output logic [CW-1:0] rd_val
);
   ch_cfg_t       cfg;
   logic          en, cap_q;
   logic [CW-1:0] duty, period;
   logic [2:0]    ie;
   logic          wr_cmd, trig, step, per_hit, at_top, edge_hit;
   logic [CW-1:0] cnt_inc;
   logic [2:0]    ev;

   assign clk_sel  = cfg.clk_sel;
   assign wr_cmd   = wr && ofs == OFS_CMD;
   assign trig     = sync | (wr_cmd & wdata[2]);
   assign step     = en & tick & ~trig;
   assign per_hit  = cfg.wave && cnt == period;
   assign at_top   = &cnt;
   assign cnt_inc  = cnt + 1'b1;
   assign edge_hit = ~cfg.wave & en &
                     ((cfg.cap_edge[0] & cap_pin & ~cap_q) |
                      (cfg.cap_edge[1] & ~cap_pin & cap_q));
   assign ev       = {edge_hit, step & per_hit, step & at_top & ~per_hit};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg    <= '0;
         en     <= 1'b0;
         duty   <= '0;
         period <= '0;
         ie     <= '0;
         cnt    <= '0;
         cap    <= '0;
         cap_q  <= 1'b0;
         status <= '0;
         out_a  <= 1'b0;
      end else begin
         cap_q <= cap_pin;
         if (wr && ofs == OFS_CTRL) cfg    <= ch_cfg_t'(wdata[5:0]);
         if (wr && ofs == OFS_DUTY) duty   <= wdata;
         if (wr && ofs == OFS_PER)  period <= wdata;
         if (wr && ofs == OFS_IE)   ie     <= wdata[2:0];
         en <= (en | (wr_cmd & wdata[0]) | trig) & ~(wr_cmd & wdata[1]);
         if (trig)                 cnt <= '0;
         else if (step && per_hit) cnt <= '0;
         else if (step)            cnt <= cnt_inc;
         if (edge_hit) cap <= cnt;
         status <= (status & ~{3{stat_rd}}) | ev;
         if (!cfg.wave)                    out_a <= 1'b0;
         else if (trig || (step && per_hit)) out_a <= 1'b1;
         else if (step && cnt_inc == duty)   out_a <= 1'b0;
      end
   end

   assign irq = |(status & ie);

   always_comb begin
      unique case (ofs)
         OFS_CTRL: rd_val = CW'(cfg);
         OFS_CMD:  rd_val = CW'(en);
         OFS_CNT:  rd_val = cnt;
         OFS_DUTY: rd_val = duty;
         OFS_PER:  rd_val = period;
         OFS_CAP:  rd_val = cap;
         OFS_STAT: rd_val = CW'(status);
         default:  rd_val = CW'(ie);
      endcase
   end
endmodule

// File: rtl/tmr_block.sv
module tmr_block
   import tmr_pkg::*;
#(
   parameter int CW   = 16,
   parameter int NCH  = 3,
   parameter int NINT = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CW-1:0]     bus_wdata,
   output logic [CW-1:0]     bus_rdata,
   input  logic [NINT-1:0]   int_clk,
   input  logic [NCH-1:0]    ext_clk,
   input  logic [NCH-1:0]    cap_in,
   output logic [NCH-1:0]    wave_out,
   output logic [NCH-1:0]    irq
);
   localparam int RW = 2 * NCH;

   if (NINT + NCH != 8) begin : g_bad_src
      $error("tmr_block: NINT + NCH must be 8");
   end
   if (NCH > 4 || CW < RW || CW < 8) begin : g_bad_size
      $error("tmr_block: NCH up to 4, CW at least 8");
   end

   logic                      blk_sel, blk_sync;
   logic [1:0]                ch_idx;
   logic [2:0]                ofs;
   logic [RW-1:0]             route;
   logic [NCH-1:0]            xc;
   logic [NCH-1:0][CW-1:0]    cnt_all, cap_all, rd_all;
   logic [NCH-1:0][2:0]       stat_all;
   logic [CW-1:0]             rd_mux;

   assign blk_sel  = bus_addr[5];
   assign ch_idx   = bus_addr[4:3];
   assign ofs      = bus_addr[2:0];
   assign blk_sync = bus_wr && blk_sel && ofs == 3'd0 && bus_wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n)                               route <= '0;
      else if (bus_wr && blk_sel && ofs == 3'd1) route <= bus_wdata[RW-1:0];
   end

   for (genvar k = 0; k < NCH; k++) begin : g_route
      always_comb begin
         unique case (route[2*k +: 2])
            2'd0:    xc[k] = ext_clk[k];
            2'd1:    xc[k] = wave_out[(k + NCH - 1) % NCH];
            default: xc[k] = 1'b0;
         endcase
      end
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic       tick, hit;
      logic [2:0] sel;
      assign hit = !blk_sel && ch_idx == 2'(i);

      tmr_clksel #(.NINT(NINT), .NXC(NCH)) u_sel (
         .clk(clk), .rst_n(rst_n), .int_tick(int_clk), .xc(xc),
         .sel(sel), .tick(tick));

      tmr_channel #(.CW(CW)) u_ch (
         .clk(clk), .rst_n(rst_n), .tick(tick), .cap_pin(cap_in[i]),
         .sync(blk_sync), .wr(bus_wr && hit),
         .stat_rd(bus_rd && hit && ofs == OFS_STAT), .ofs(ofs),
         .wdata(bus_wdata), .clk_sel(sel), .out_a(wave_out[i]),
         .irq(irq[i]), .cnt(cnt_all[i]), .cap(cap_all[i]),
         .status(stat_all[i]), .rd_val(rd_all[i]));
   end

   always_comb begin
      rd_mux = '0;
      if (blk_sel) begin
         if (ofs == 3'd1) rd_mux = CW'(route);
      end else begin
         for (int i = 0; i < NCH; i++)
            if (ch_idx == 2'(i)) rd_mux = rd_all[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end
endmodule

module tmr_block_chk #(
   parameter int CW  = 16,
   parameter int NCH = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_wr,
   input logic [5:0]             bus_addr,
   input logic [CW-1:0]          bus_wdata,
   input logic [NCH-1:0]         irq,
   input logic [NCH-1:0][CW-1:0] cnt_all,
   input logic [NCH-1:0][CW-1:0] cap_all,
   input logic [NCH-1:0][2:0]    stat_all
);
   for (genvar i = 0; i < NCH; i++) begin : g_p
      p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_all[i] != $past(cnt_all[i]) |->
            (cnt_all[i] == $past(cnt_all[i]) + 1'b1 || cnt_all[i] == '0));
      p_sync_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
         $past(bus_wr && bus_addr == 6'h20 && bus_wdata[0]) |-> cnt_all[i] == '0);
      p_capture_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
         cap_all[i] != $past(cap_all[i]) |-> stat_all[i][2]);
      p_wrap_from_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(stat_all[i][0]) |-> &$past(cnt_all[i]));
      p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
         irq[i] |-> stat_all[i] != 3'b000);
   end
endmodule

bind tmr_block tmr_block_chk #(.CW(CW), .NCH(NCH)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .irq(irq), .cnt_all(cnt_all),
   .cap_all(cap_all), .stat_all(stat_all));

// File: tb/sim_tmr_block.sv
`timescale 1ns/1ps
module sim_tmr_block;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [4:0]  int_clk = '0;
   logic [2:0]  ext_clk = '0;
   logic [2:0]  cap_in = '0;
   logic [2:0]  wave_out, irq;

   int checks = 0, errors = 0;
   int exp_q[$];
   string tag_q[$];
   logic rd_seen = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tmr_block u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .int_clk(int_clk), .ext_clk(ext_clk), .cap_in(cap_in),
      .wave_out(wave_out), .irq(irq));

   task automatic check(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got %0h exp %0h", tag, got, exp);
      end
   endtask

   // monitor: read data is due on the falling edge after the strobe edge
   always @(posedge clk) rd_seen <= bus_rd;
   always @(negedge clk) begin
      if (rd_seen && exp_q.size() > 0) begin
         int e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, int'(bus_rdata), e);
      end
   end

   task automatic wr(input int a, input int d);
      bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = 16'(d);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, input int e, input string t);
      bus_rd = 1'b1; bus_addr = 6'(a);
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      bus_rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_int(input int k, input int n);
      for (int j = 0; j < n; j++) begin
         int_clk[k] = 1'b1; @(negedge clk);
         int_clk[k] = 1'b0; @(negedge clk);
      end
   endtask

   task automatic pulse_ext(input int k, input int n);
      for (int j = 0; j < n; j++) begin
         ext_clk[k] = 1'b1; @(negedge clk);
         ext_clk[k] = 1'b0; @(negedge clk);
      end
   endtask

   initial begin
      #(5.0 * 190000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 wave_out", int'(wave_out), 0);
      check("R1 irq", int'(irq), 0);
      rd(2, 0, "R1 ch0 count");
      rd(6, 0, "R1 ch0 status");
      rd(1, 0, "R1 ch0 stopped");

      // R2 count from internal tap 0
      wr(0, 0); wr(1, 1);
      pulse_int(0, 5);
      rd(2, 5, "R2 ch0 count");
      rd(1, 1, "R3 ch0 enabled");
      // R3 disable stops counting
      wr(1, 2);
      pulse_int(0, 3);
      rd(2, 5, "R3 disabled count held");
      rd(1, 0, "R3 ch0 disabled");

      // R4 block sync
      wr(8, 0); wr(16, 0);
      wr(32, 1);
      rd(2, 0, "R4 ch0 cleared");
      rd(10, 0, "R4 ch1 cleared");
      rd(18, 0, "R4 ch2 cleared");
      rd(17, 1, "R4 ch2 started");
      pulse_int(0, 3);
      rd(2, 3, "R4 ch0 aligned");
      rd(10, 3, "R4 ch1 aligned");
      rd(18, 3, "R4 ch2 aligned");

      // R6/R7 waveform on ch1, tap 1, period 4, duty 2
      wr(8, 9); wr(11, 2); wr(12, 4); wr(15, 2);
      wr(9, 4);
      check("R7 set on trigger", int'(wave_out[1]), 1);
      pulse_int(1, 1); check("R7 count1 high", int'(wave_out[1]), 1);
      pulse_int(1, 1); check("R7 duty clear", int'(wave_out[1]), 0);
      pulse_int(1, 2); check("R7 stays low", int'(wave_out[1]), 0);
      check("R10 irq before match", int'(irq[1]), 0);
      pulse_int(1, 1); check("R7 period set", int'(wave_out[1]), 1);
      check("R10 irq on period", int'(irq[1]), 1);
      rd(10, 0, "R6 count restarted");
      rd(14, 2, "R6 period flag");
      check("R10 irq cleared by read", int'(irq[1]), 0);
      rd(14, 0, "R10 status cleared");

      // R9 overflow on ch2, tap 2, rising capture
      wr(16, 18); wr(23, 1); wr(17, 4);
      pulse_int(2, 65535);
      rd(18, 16'hFFFF, "R9 count at top");
      check("R9 no irq before wrap", int'(irq[2]), 0);
      pulse_int(2, 1);
      check("R9 irq on wrap", int'(irq[2]), 1);
      rd(18, 0, "R9 wrapped");
      rd(22, 1, "R9 overflow flag");

      // R8 capture
      pulse_int(2, 7);
      cap_in[2] = 1'b1; @(negedge clk);
      rd(21, 7, "R8 capture rise");
      check("R10 capture masked", int'(irq[2]), 0);
      rd(22, 4, "R8 capture flag");
      pulse_int(2, 2);
      cap_in[2] = 1'b0; @(negedge clk);
      rd(21, 7, "R8 fall ignored");
      rd(22, 0, "R8 no flag on fall");

      // R5 chaining ch0 -> ch1 through routed line 1, ch2 on ext pin 2
      wr(0, 8); wr(3, 1); wr(4, 1);
      wr(8, 6); wr(16, 7);
      wr(33, 4);
      rd(33, 4, "R5 routing readback");
      wr(32, 1);
      check("R7 ch0 set by sync", int'(wave_out[0]), 1);
      pulse_int(0, 4);
      rd(10, 3, "R5 chained count");
      check("R7 ch0 toggled", int'(wave_out[0]), 1);
      pulse_ext(2, 2);
      rd(18, 2, "R5 ext pin count");

      @(negedge clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule